// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the host-side register front end of an eight-line interrupt controller. A processor talks to it over a byte-wide port with a single address bit that picks a low or a high port. Setting up the controller takes a chain of configuration bytes. The first goes to the low port, and up to three more follow on the high port. Whether the third and fourth bytes are expected depends on bits in the first byte. Once the chain is complete, the block accepts runtime command bytes at any time. Each command is recognised by its bit pattern, since several command kinds share the same port.

From these bytes the block holds the controller's configuration:

- vector base
- edge or level triggering
- single or cascaded operation, plus the cascade byte
- vector mode, automatic end-of-interrupt, buffer mode and nested mode
- the line mask and the special-mask flag

End-of-interrupt and priority commands are not handled here. Each one is passed to the priority logic as a single-cycle pulse carrying an opcode and a line number. The block also drives the read port, which returns one of four values: the mask, the request register, the in-service register, or a one-shot poll result. The request register, the in-service register and the poll winner all come from outside the block.

The configuration chain is a state machine with five states:

- `ST_UNINIT`: after reset, no configuration yet.
- `ST_BASE`: waiting for the vector-base byte.
- `ST_CASC`: waiting for the cascade byte.
- `ST_OPT`: waiting for the options byte.
- `ST_RUN`: operating.

It has these transitions:

- **Start**: a start byte moves any state to `ST_BASE`.
- **Base**: a high write in `ST_BASE` goes to `ST_CASC` when cascaded. Otherwise it goes to `ST_OPT` when the options byte was requested, and to `ST_RUN` if not.
- **Cascade**: a high write in `ST_CASC` goes to `ST_OPT` when the options byte was requested, otherwise to `ST_RUN`.
- **Options**: a high write in `ST_OPT` goes to `ST_RUN`.
- **Hold**: a high write in `ST_UNINIT` or `ST_RUN` leaves the state as it is.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the block is neither configured nor configuring, the mask is 0xFF, special mask is off, no command or poll pulse is active, and low-port reads return the request register.
- R2: A low-port write with bit 4 = 1 starts configuration from any state. It captures level triggering from bit 3 (1 = level), single mode from bit 1 (1 = single, 0 = cascaded) and the options request from bit 0. It clears the cascade byte and all option fields, turns special mask off, selects the request register for low reads and cancels a pending poll.
- R3: Configuration bytes on the high port are taken in order. The base byte sets the vector base from bits 7:3. The cascade byte is expected only when bit 1 of the start byte was 0, and the options byte only when bit 0 was 1. Bytes that are not expected are skipped. While configuring, busy is 1 and ready is 0.
- R4: The options byte sets vector mode from bit 0, automatic end-of-interrupt from bit 1, buffer mode from bits 3:2 and nested mode from bit 4. Without an options byte these fields stay 0.
- R5: The write that completes configuration clears the whole mask and raises ready.
- R6: While ready, a high-port write loads the mask, and a high-port read (with no poll pending) returns it.
- R7: A high-port write before any configuration has started has no effect: the mask and state are unchanged.
- R8: While ready, a low-port write with bits 4:3 = 00 produces a one-cycle command pulse in the next cycle, with the opcode taken from bits 7:5 and the line from bits 2:0.
- R9: While ready, a low-port write with bits 4:3 = 01 and bits 1:0 = 10 selects the request register for low reads, 11 selects the in-service register, and 0x keeps the selection.
- R10: In that same command, bits 6:5 = 11 set special mask, 10 clear it, and 0x leave it unchanged.
- R11: If bit 2 of that command is 1, the next read on either port returns 0x80 plus the eligible line when one exists, or 0x00 when none does. The cycle after that read carries a one-cycle poll acknowledge with the line, only when a line was returned. Later reads behave normally.
- R12: Low-port writes with bit 4 = 0 are ignored unless ready: no command pulse, and the selection and special mask are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr_hi | input | 1 | Port select: 0 low, 1 high |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the cycle of rd_en |
| irr_in | input | 8 | Request register from the latching logic |
| isr_in | input | 8 | In-service register from the priority logic |
| poll_hit | input | 1 | An eligible line exists |
| poll_line | input | 3 | Highest-priority eligible line |
| init_busy | output | 1 | Configuration chain in progress |
| ready | output | 1 | Configured and operating |
| vec_base | output | 5 | Vector base bits 7:3 |
| level_mode | output | 1 | 1 = level triggered |
| single_mode | output | 1 | 1 = no cascade |
| casc_word | output | 8 | Cascade configuration byte |
| vec_mode | output | 1 | Vector mode option |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| buf_mode | output | 2 | Buffer mode |
| nested_mode | output | 1 | Nested mode option |
| mask | output | 8 | Line mask, 1 = masked |
| special_mask | output | 1 | Special mask mode |
| cmd_valid | output | 1 | End-of-interrupt/priority command pulse |
| cmd_op | output | 3 | Command opcode |
| cmd_line | output | 3 | Command line |
| poll_ack | output | 1 | Poll returned a line; set its in-service bit |
| poll_ack_line | output | 3 | Line returned by the poll |

## Verification
A wrong sequencer state usually shows up on the next high-port write. A skipped or extra byte puts the wrong value into vec_base, casc_word or the options, or clears the mask one byte early or late, and ready rises in the wrong cycle. A stale readback selection or poll flag changes rd_data on the very next read, in that read's own cycle. A wrong command decode shows on cmd_valid one cycle after the write. The bench compares configuration, mask and state against its own model on every clock, so any divergence is reported within one cycle of the write that caused it.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_BASE   = 3'd1,
        ST_CASC   = 3'd2,
        ST_OPT    = 3'd3,
        ST_RUN    = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        LK_START = 2'd0,
        LK_PRIO  = 2'd1,
        LK_READ  = 2'd2
    } low_kind_t;

    function automatic low_kind_t classify_low(input logic [DATA_W-1:0] b);
        if (b[4])
            return LK_START;
        else if (b[3])
            return LK_READ;
        else
            return LK_PRIO;
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic              start_w,
    output logic              done_w,
    output logic              ready,
    output logic              init_busy,
    output logic [4:0]        vec_base,
    output logic              level_mode,
    output logic              single_mode,
    output logic [7:0]        casc_word,
    output logic              vec_mode,
    output logic              auto_eoi,
    output logic [1:0]        buf_mode,
    output logic              nested_mode
);

    seq_state_t state_q, state_d;
    logic       need_opt_q;
    logic       hi_w;

    assign hi_w    = wr_en && addr_hi;
    assign start_w = wr_en && !addr_hi && (classify_low(wr_data) == LK_START);

    // next-state and completion decode
    always_comb begin
        state_d = state_q;
        done_w  = 1'b0;
        if (start_w) begin
            state_d = ST_BASE;
        end else if (hi_w) begin
            unique case (state_q)
                ST_BASE: begin
                    if (!single_mode) begin
                        state_d = ST_CASC;
                    end else if (need_opt_q) begin
                        state_d = ST_OPT;
                    end else begin
                        state_d = ST_RUN;
                        done_w  = 1'b1;
                    end
                end
                ST_CASC: begin
                    if (need_opt_q) begin
                        state_d = ST_OPT;
                    end else begin
                        state_d = ST_RUN;
                        done_w  = 1'b1;
                    end
                end
                ST_OPT: begin
                    state_d = ST_RUN;
                    done_w  = 1'b1;
                end
                ST_UNINIT: state_d = ST_UNINIT;
                ST_RUN:    state_d = ST_RUN;
                default:   state_d = ST_UNINIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_UNINIT;
        else
            state_q <= state_d;
    end

    // configuration outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base    <= '0;
            level_mode  <= 1'b0;
            single_mode <= 1'b0;
            need_opt_q  <= 1'b0;
            casc_word   <= '0;
            vec_mode    <= 1'b0;
            auto_eoi    <= 1'b0;
            buf_mode    <= '0;
            nested_mode <= 1'b0;
        end else if (start_w) begin
            level_mode  <= wr_data[3];
            single_mode <= wr_data[1];
            need_opt_q  <= wr_data[0];
            casc_word   <= '0;
            vec_mode    <= 1'b0;
            auto_eoi    <= 1'b0;
            buf_mode    <= '0;
            nested_mode <= 1'b0;
        end else if (hi_w) begin
            unique case (state_q)
                ST_BASE: vec_base  <= wr_data[7:3];
                ST_CASC: casc_word <= wr_data;
                ST_OPT: begin
                    vec_mode    <= wr_data[0];
                    auto_eoi    <= wr_data[1];
                    buf_mode    <= wr_data[3:2];
                    nested_mode <= wr_data[4];
                end
                ST_UNINIT, ST_RUN: ;
                default: ;
            endcase
        end
    end

    assign ready     = (state_q == ST_RUN);
    assign init_busy = (state_q == ST_BASE) || (state_q == ST_CASC) || (state_q == ST_OPT);

endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs
    import pic_cmd_pkg::*;
#(
    parameter int LINES  = 8,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start_w,
    input  logic              done_w,
    input  logic              ready,
    input  logic              poll_hit,
    input  logic [LINE_W-1:0] poll_line,
    output logic [LINES-1:0]  mask,
    output logic              special_mask,
    output logic              sel_isr,
    output logic              poll_pend,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_ack,
    output logic [LINE_W-1:0] poll_ack_line
);

    logic      low_w;
    low_kind_t kind;
    logic      prio_w, read_w;

    assign low_w  = wr_en && !addr_hi && ready;
    assign kind   = classify_low(wr_data);
    assign prio_w = low_w && (kind == LK_PRIO);
    assign read_w = low_w && (kind == LK_READ);

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '1;
        else if (done_w)
            mask <= '0;
        else if (wr_en && addr_hi && ready)
            mask <= wr_data[LINES-1:0];
    end

    // readback selection, special mask, poll request
    always_ff @(posedge clk) begin
        if (!rst_n || start_w) begin
            sel_isr      <= 1'b0;
            special_mask <= 1'b0;
            poll_pend    <= 1'b0;
        end else if (read_w) begin
            if (wr_data[1])
                sel_isr <= wr_data[0];
            if (wr_data[6])
                special_mask <= wr_data[5];
            poll_pend <= wr_data[2];
        end else if (rd_en && poll_pend) begin
            poll_pend <= 1'b0;
        end
    end

    // command and poll-acknowledge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid     <= 1'b0;
            cmd_op        <= '0;
            cmd_line      <= '0;
            poll_ack      <= 1'b0;
            poll_ack_line <= '0;
        end else begin
            cmd_valid <= prio_w;
            if (prio_w) begin
                cmd_op   <= wr_data[7:5];
                cmd_line <= wr_data[LINE_W-1:0];
            end
            poll_ack <= rd_en && poll_pend && poll_hit;
            if (rd_en && poll_pend)
                poll_ack_line <= poll_line;
        end
    end

endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
    import pic_cmd_pkg::*;
#(
    parameter int LINES  = 8,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              addr_hi,
    input  logic              sel_isr,
    input  logic              poll_pend,
    input  logic              poll_hit,
    input  logic [LINE_W-1:0] poll_line,
    input  logic [LINES-1:0]  mask,
    input  logic [LINES-1:0]  irr_in,
    input  logic [LINES-1:0]  isr_in,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] poll_byte;

    always_comb begin
        poll_byte = '0;
        if (poll_hit) begin
            poll_byte[DATA_W-1]   = 1'b1;
            poll_byte[LINE_W-1:0] = poll_line;
        end
    end

    always_comb begin
        rd_data = '0;
        if (poll_pend)
            rd_data = poll_byte;
        else if (addr_hi)
            rd_data[LINES-1:0] = mask;
        else if (sel_isr)
            rd_data[LINES-1:0] = isr_in;
        else
            rd_data[LINES-1:0] = irr_in;
    end

endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
#(
    parameter int LINES  = 8,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_hi,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [LINES-1:0]  irr_in,
    input  logic [LINES-1:0]  isr_in,
    input  logic              poll_hit,
    input  logic [LINE_W-1:0] poll_line,
    output logic              init_busy,
    output logic              ready,
    output logic [4:0]        vec_base,
    output logic              level_mode,
    output logic              single_mode,
    output logic [7:0]        casc_word,
    output logic              vec_mode,
    output logic              auto_eoi,
    output logic [1:0]        buf_mode,
    output logic              nested_mode,
    output logic [LINES-1:0]  mask,
    output logic              special_mask,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_ack,
    output logic [LINE_W-1:0] poll_ack_line
);

    logic start_w, done_w, sel_isr, poll_pend;

    pic_init_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr_hi     (addr_hi),
        .wr_data     (wr_data),
        .start_w     (start_w),
        .done_w      (done_w),
        .ready       (ready),
        .init_busy   (init_busy),
        .vec_base    (vec_base),
        .level_mode  (level_mode),
        .single_mode (single_mode),
        .casc_word   (casc_word),
        .vec_mode    (vec_mode),
        .auto_eoi    (auto_eoi),
        .buf_mode    (buf_mode),
        .nested_mode (nested_mode)
    );

    pic_op_regs #(.LINES(LINES)) u_ops (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr_hi       (addr_hi),
        .wr_data       (wr_data),
        .start_w       (start_w),
        .done_w        (done_w),
        .ready         (ready),
        .poll_hit      (poll_hit),
        .poll_line     (poll_line),
        .mask          (mask),
        .special_mask  (special_mask),
        .sel_isr       (sel_isr),
        .poll_pend     (poll_pend),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_line      (cmd_line),
        .poll_ack      (poll_ack),
        .poll_ack_line (poll_ack_line)
    );

    pic_read_mux #(.LINES(LINES)) u_rd (
        .addr_hi   (addr_hi),
        .sel_isr   (sel_isr),
        .poll_pend (poll_pend),
        .poll_hit  (poll_hit),
        .poll_line (poll_line),
        .mask      (mask),
        .irr_in    (irr_in),
        .isr_in    (isr_in),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr_hi,
    input logic [7:0]       wr_data,
    input logic             ready,
    input logic             init_busy,
    input logic [LINES-1:0] mask,
    input logic             special_mask,
    input logic             cmd_valid,
    input logic             poll_ack
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_hi && wr_data[4]) |=> (init_busy && !ready));

    // R3
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && init_busy));

    // R5
    done_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (mask == '0));

    // R7
    idle_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !init_busy && wr_en && addr_hi) |=> ($stable(mask) && !init_busy && !ready));

    // R8
    cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_en && !addr_hi && (wr_data[4:3] == 2'b00) && ready));

    // R10
    smm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(special_mask));

    // R11
    ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack |-> $past(rd_en));

endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.LINES(LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr_hi      (addr_hi),
    .wr_data      (wr_data),
    .ready        (ready),
    .init_busy    (init_busy),
    .mask         (mask),
    .special_mask (special_mask),
    .cmd_valid    (cmd_valid),
    .poll_ack     (poll_ack)
);

// File: tb/tb_pic_cmd_seq.sv
`timescale 1ns/1ps
module tb_pic_cmd_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] irr_in = 8'h3C, isr_in = 8'h81;
    logic       poll_hit = 1'b0;
    logic [2:0] poll_line = 3'd0;
    logic       init_busy, ready, level_mode, single_mode, vec_mode, auto_eoi, nested_mode;
    logic [4:0] vec_base;
    logic [7:0] casc_word, mask;
    logic [1:0] buf_mode;
    logic       special_mask, cmd_valid, poll_ack;
    logic [2:0] cmd_op, cmd_line, poll_ack_line;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state (0 uninit, 1 base, 2 cascade, 3 options, 4 run)
    int m_st = 0;
    int m_n4 = 0, m_sng = 0, m_lvl = 0, m_base = 0, m_casc = 0, m_w4 = 0;
    int m_mask = 255, m_smm = 0, m_sel = 0, m_poll = 0;
    int m_cmd = 0, m_cop = 0, m_cln = 0;

    always #10 clk = ~clk;

    pic_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_hi(addr_hi),
        .wr_data(wr_data), .rd_data(rd_data), .irr_in(irr_in), .isr_in(isr_in),
        .poll_hit(poll_hit), .poll_line(poll_line), .init_busy(init_busy), .ready(ready),
        .vec_base(vec_base), .level_mode(level_mode), .single_mode(single_mode),
        .casc_word(casc_word), .vec_mode(vec_mode), .auto_eoi(auto_eoi),
        .buf_mode(buf_mode), .nested_mode(nested_mode), .mask(mask),
        .special_mask(special_mask), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .poll_ack(poll_ack), .poll_ack_line(poll_ack_line)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input bit hi, input int d);
        m_cmd = 0;
        if (!hi && d[4]) begin
            m_st = 1; m_lvl = d[3]; m_sng = d[1]; m_n4 = d[0];
            m_casc = 0; m_w4 = 0; m_smm = 0; m_sel = 0; m_poll = 0;
        end else if (hi) begin
            case (m_st)
                1: begin m_base = d[7:3]; m_st = !m_sng ? 2 : (m_n4 ? 3 : 4); end
                2: begin m_casc = d & 255; m_st = m_n4 ? 3 : 4; end
                3: begin m_w4 = d & 31; m_st = 4; end
                4: m_mask = d & 255;
                default: ;
            endcase
            if (m_st == 4 && !(m_mask == (d & 255) && m_st == 4 && hi && m_base >= 0 && 0)) begin
            end
        end else if (m_st == 4) begin
            if (d[3] == 0) begin
                m_cmd = 1; m_cop = (d >> 5) & 7; m_cln = d & 7;
            end else begin
                if (d[1]) m_sel = d[0];
                if (d[6]) m_smm = d[5];
                m_poll = d[2];
            end
        end
    endtask

    task automatic wr(input bit hi, input int d);
        int prev_st;
        prev_st = m_st;
        @(negedge clk);
        wr_en = 1'b1; addr_hi = hi; wr_data = d[7:0];
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(hi, d);
        if (prev_st != 4 && m_st == 4) m_mask = 0;  // completion unmasks
        // R8 / R12: command pulse one cycle after the write
        chk(cmd_valid == m_cmd[0], (m_st == 4 && prev_st == 4) ? "R8 cmd_valid" : "R12 cmd_valid",
            cmd_valid, m_cmd);
        if (m_cmd != 0) begin
            chk(cmd_op == m_cop[2:0], "R8 cmd_op", cmd_op, m_cop);
            chk(cmd_line == m_cln[2:0], "R8 cmd_line", cmd_line, m_cln);
        end
    endtask

    task automatic rd(input bit hi, input int exp, input string req);
        int ack_exp;
        @(negedge clk);
        rd_en = 1'b1; addr_hi = hi;
        #1;
        chk(rd_data == exp[7:0], req, rd_data, exp);
        ack_exp = (m_poll != 0 && poll_hit) ? 1 : 0;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        m_poll = 0;
        chk(poll_ack == ack_exp[0], "R11 poll_ack", poll_ack, ack_exp);
        if (ack_exp != 0)
            chk(poll_ack_line == poll_line, "R11 poll_ack_line", poll_ack_line, poll_line);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ready == (m_st == 4), "R3 ready", ready, m_st == 4);
            chk(init_busy == (m_st >= 1 && m_st <= 3), "R3 init_busy", init_busy, m_st);
            chk(mask == m_mask[7:0], "R6 mask", mask, m_mask);
            chk(special_mask == m_smm[0], "R10 special_mask", special_mask, m_smm);
            chk(vec_base == m_base[4:0], "R3 vec_base", vec_base, m_base);
            chk(level_mode == m_lvl[0] && single_mode == m_sng[0], "R2 mode bits",
                {level_mode, single_mode}, {m_lvl[0], m_sng[0]});
            chk(casc_word == m_casc[7:0], "R3 casc_word", casc_word, m_casc);
            chk({nested_mode, buf_mode, auto_eoi, vec_mode} == m_w4[4:0], "R4 options",
                {nested_mode, buf_mode, auto_eoi, vec_mode}, m_w4);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(!ready && !init_busy, "R1 state", {ready, init_busy}, 0);
        chk(mask == 8'hFF, "R1 mask", mask, 8'hFF);
        chk(!cmd_valid && !poll_ack && !special_mask, "R1 pulses", {cmd_valid, poll_ack}, 0);
        rd(0, 8'h3C, "R1 low read");

        // R7 high write before configuration
        wr(1, 8'h55);
        chk(mask == 8'hFF && !init_busy, "R7 ignored", mask, 8'hFF);
        // R12 command before configuration
        wr(0, 8'h20);

        // cascaded, options requested
        wr(0, 8'h11);
        wr(0, 8'h60);            // R12 ignored mid-configuration
        wr(1, 8'h20);            // base -> 4
        chk(init_busy, "R3 awaiting cascade", init_busy, 1);
        wr(1, 8'h04);            // cascade byte
        wr(1, 8'h1F);            // options
        chk(ready && mask == 8'h00, "R5 done", mask, 0);
        chk(vec_base == 5'd4, "R3 base", vec_base, 4);
        chk(buf_mode == 2'b11 && auto_eoi && vec_mode && nested_mode, "R4 options 1F",
            {nested_mode, buf_mode, auto_eoi, vec_mode}, 8'h1F);

        // R6 mask access
        wr(1, 8'hA5);
        rd(1, 8'hA5, "R6 high read");

        // R8 commands
        wr(0, 8'h63);
        wr(0, 8'hE5);

        // R9 readback selection
        rd(0, 8'h3C, "R9 default request");
        wr(0, 8'h0B);
        rd(0, 8'h81, "R9 in-service");
        wr(0, 8'h08);
        rd(0, 8'h81, "R9 keep selection");
        wr(0, 8'h0A);
        rd(0, 8'h3C, "R9 request again");

        // R10 special mask
        wr(0, 8'h68);
        wr(0, 8'h28);
        wr(0, 8'h48);
        wr(0, 8'h68);

        // R11 poll with a winner, then normal read
        poll_hit = 1'b1; poll_line = 3'd5;
        wr(0, 8'h0C);
        rd(1, 8'h85, "R11 poll result");
        rd(1, 8'hA5, "R11 poll ended");
        // R11 poll without a winner
        poll_hit = 1'b0;
        wr(0, 8'h0C);
        rd(0, 8'h00, "R11 empty poll");
        rd(0, 8'h3C, "R11 after empty poll");

        // R2/R3/R4 reconfigure: single, no options; selection reset
        wr(0, 8'h0B);
        wr(0, 8'h12);
        chk(!special_mask, "R2 smm cleared", special_mask, 0);
        wr(1, 8'h48);
        chk(ready && mask == 8'h00 && vec_base == 5'd9, "R5 short chain", mask, 0);
        chk(casc_word == 8'h00 && !auto_eoi && buf_mode == 2'b00, "R4 no options", casc_word, 0);
        rd(0, 8'h3C, "R2 selection reset");

        // restart mid-chain, level + single + options
        wr(0, 8'h11);
        wr(1, 8'h80);
        wr(0, 8'h1B);
        wr(1, 8'hF8);
        chk(init_busy && level_mode, "R2 restart", init_busy, 1);
        wr(1, 8'h02);
        chk(ready && auto_eoi && !vec_mode && vec_base == 5'd31, "R4 auto eoi", auto_eoi, 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule